// File: doc/BRIEF.md
# Decade Counter with Rising/Falling Advance Inputs

This block is a four-bit decade counter that runs from one system clock. Two slow external control lines are over-sampled on that clock. A rising transition on the first line advances the count when the second line is high. A falling transition on the second line advances the count when the first line is low. Either line can therefore act as the count clock, with the other acting as a level enable.

The count runs 0 to 9 and wraps. A terminal-count flag is high on 9, so several instances can be chained into a multi-digit counter.

A master clear input acts on the counter at once, with no clock needed, and holds it at zero while it is high. Release of the master clear is aligned to the system clock. Edges that arrive while the counter is still coming out of the clear are discarded.

Top module: `bcd_dual_edge_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and `tc_o` is 0.
- R2: A low-to-high change on `ck_rise_i` while `ck_fall_i` is high advances `count_o` by one.
- R3: A high-to-low change on `ck_fall_i` while `ck_rise_i` is low advances `count_o` by one.
- R4: Every other change leaves `count_o` unchanged. This covers a rise on `ck_rise_i` with `ck_fall_i` low, a fall on `ck_fall_i` with `ck_rise_i` high, the opposite edge on either line, and steady levels.
- R5: When a qualified rise on `ck_rise_i` and a qualified fall on `ck_fall_i` are applied in the same clock cycle, the count advances by exactly one. Each edge is qualified by the other line's level before the change.
- R6: The count follows 0,1,...,9 and then returns to 0. It never shows a value above 9.
- R7: While `mr_i` is high, `count_o` is 0. The clear takes effect as soon as `mr_i` rises, with no clock edge needed, and edges on either line are ignored for as long as it stays high.
- R8: An edge applied in the same cycle that `mr_i` is released is not counted. The count stays 0 until a later qualified edge arrives.
- R9: `tc_o` is high exactly when `count_o` equals 9.
- R10: An input change made between clock edges appears on `count_o` after the third rising edge of `clk` that follows it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mr_i | input | 1 | Master clear, active high; clears at once, release is synchronous |
| ck_rise_i | input | 1 | Advances on its rising edge when `ck_fall_i` is high |
| ck_fall_i | input | 1 | Advances on its falling edge when `ck_rise_i` is low |
| count_o | output | 4 | BCD count, bit 0 least significant |
| tc_o | output | 1 | High when the count is 9 |

## Verification
The step assertions assume two things. First, `mr_i` stays high for at least one full clock cycle. Second, the two control lines hold each level long enough for the synchronisers to capture it, so a clear or an edge is never shorter than one clock cycle. The stimulus changes inputs only on falling clock edges. After each change it waits four cycles before the next one, and every master clear is held for several cycles. Random level pairs, random clears and directed cases reach every row of the mode table, including both lines changing together, the wrap past 9 and an edge coinciding with the clear release.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
  localparam int DIGIT_W  = 4;
  localparam int DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Next decade value; 9 and any illegal code fall back to zero.
  function automatic digit_t digit_inc(input digit_t d);
    if (d >= digit_t'(DIGIT_MAX)) return '0;
    return d + digit_t'(1);
  endfunction
endpackage

// File: rtl/bcdc_sync.sv
module bcdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bcdc_edge_qual.sv
module bcdc_edge_qual (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_i,   // [0] rise line, [1] fall line, synchronised
  output logic       adv_o
);
  logic [1:0] prev_q;
  logic       rise_ok;
  logic       fall_ok;

  // Enable level is the other line's value before the edge.
  always_comb begin
    rise_ok = lvl_i[0] & ~prev_q[0] &  prev_q[1];
    fall_ok = ~lvl_i[1] & prev_q[1] & ~prev_q[0];
    adv_o   = rise_ok | fall_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= lvl_i;
  end

  AST_NO_ADV_ON_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == prev_q) |-> !adv_o); // R4
endmodule

// File: rtl/bcdc_core.sv
module bcdc_core
  import bcdc_pkg::*;
#(
  parameter int HOLD_CYCLES = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mr_i,
  input  logic   adv_i,
  output digit_t count_o,
  output logic   tc_o
);
  logic                   clr_n;
  logic [HOLD_CYCLES-1:0] hold_q;
  logic [HOLD_CYCLES-1:0] hold_d;
  logic                   adv_ok;
  logic                   cnt_en;
  digit_t                 cnt_q;
  digit_t                 cnt_d;

  assign clr_n = rst_n & ~mr_i;

  always_comb begin
    hold_d = {hold_q[HOLD_CYCLES-2:0], 1'b0};
    adv_ok = adv_i & (hold_q == '0);
    cnt_en = adv_ok;
    cnt_d  = digit_inc(cnt_q);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) hold_q <= '1;
    else        hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign tc_o    = (cnt_q == digit_t'(DIGIT_MAX));

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= digit_t'(DIGIT_MAX)); // R6
  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mr_i |-> (count_o == '0)); // R7
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n || mr_i)
    !$stable(count_o) |-> (count_o == digit_inc($past(count_o)))); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || mr_i)
    (tc_o && adv_ok) |=> (count_o == '0)); // R6
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || mr_i)
    (hold_q != '0) |=> $stable(count_o)); // R8
endmodule

// File: rtl/bcd_dual_edge_counter.sv
module bcd_dual_edge_counter
  import bcdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mr_i,
  input  logic       ck_rise_i,
  input  logic       ck_fall_i,
  output logic [3:0] count_o,
  output logic       tc_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lvl;
  logic [N_LINES-1:0] syn_lvl;
  logic               adv;
  digit_t             cnt;

  assign raw_lvl = {ck_fall_i, ck_rise_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    bcdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lvl[g]),
      .q_o   (syn_lvl[g])
    );
  end

  bcdc_edge_qual u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (syn_lvl),
    .adv_o (adv)
  );

  bcdc_core #(.HOLD_CYCLES(HOLD_CYCLES)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mr_i    (mr_i),
    .adv_i   (adv),
    .count_o (cnt),
    .tc_o    (tc_o)
  );

  assign count_o = cnt;

  AST_STEADY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n || mr_i)
    !adv |=> $stable(count_o)); // R4
  AST_TC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> (count_o == 4'd9)); // R9
endmodule

// File: tb/tb_bcd_dual_edge_counter.sv
`timescale 1ns/1ps
module tb_bcd_dual_edge_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mr_i;
  logic       ck_rise_i;
  logic       ck_fall_i;
  logic [3:0] count_o;
  logic       tc_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   exp_cnt  = 0;
  bit   done     = 0;

  bcd_dual_edge_counter dut (
    .clk(clk), .rst_n(rst_n), .mr_i(mr_i),
    .ck_rise_i(ck_rise_i), .ck_fall_i(ck_fall_i),
    .count_o(count_o), .tc_o(tc_o)
  );

  always #2.5 clk = ~clk;

  function automatic bit qualifies(bit o0, bit o1, bit n0, bit n1);
    bit r, f;
    r = !o0 && n0 && o1;
    f = o1 && !n1 && !o0;
    return r || f;
  endfunction

  function automatic int next_dec(int v);
    return (v >= 9) ? 0 : v + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(string req);
    check(req, int'(count_o), exp_cnt);
    check("R9", int'(tc_o), (exp_cnt == 9) ? 1 : 0);
  endtask

  // Apply a new level pair at a falling edge, wait, then compare.
  task automatic step(bit n0, bit n1, string req);
    bit o0, o1;
    @(negedge clk);
    o0 = ck_rise_i; o1 = ck_fall_i;
    if (qualifies(o0, o1, n0, n1)) exp_cnt = next_dec(exp_cnt);
    ck_rise_i = n0; ck_fall_i = n1;
    repeat (4) @(posedge clk);
    #1 check_out(req);
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    mr_i = 1'b1;
    #1 check("R7", int'(count_o), 0);
    exp_cnt = 0;
    @(negedge clk); ck_rise_i = ~ck_rise_i;
    @(negedge clk); ck_fall_i = ~ck_fall_i;
    repeat (4) @(posedge clk);
    #1 check("R7", int'(count_o), 0);
    @(negedge clk);
    mr_i = 1'b0;
    repeat (6) @(posedge clk);
    #1 check_out("R7");
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4518));
    rst_n = 1'b0; mr_i = 1'b0; ck_rise_i = 1'b0; ck_fall_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", int'(count_o), 0);
    check("R1", int'(tc_o), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(posedge clk);

    // R10: exact latency of a rise on the first line
    @(negedge clk) ck_rise_i = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 check("R10", int'(count_o), 0);
    @(posedge clk);
    #1 check("R10", int'(count_o), 1);
    exp_cnt = 1;

    step(1'b0, 1'b1, "R4");   // falling on rise line: no count
    step(1'b0, 1'b0, "R3");   // fall with rise line low: count
    step(1'b1, 1'b0, "R4");   // rise with fall line low: no count
    step(1'b1, 1'b1, "R4");   // rise on fall line: no count
    step(1'b1, 1'b0, "R4");   // fall with rise line high: no count
    step(1'b0, 1'b1, "R4");   // both opposite edges: no count
    step(1'b1, 1'b0, "R5");   // both qualified together: one count
    step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, "R4");   // steady levels

    // R6: run through the wrap
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, "R6");
    end

    clear_pulse();

    // R8: edge together with clear release is dropped
    @(negedge clk) begin mr_i = 1'b1; ck_rise_i = 1'b0; ck_fall_i = 1'b1; end
    exp_cnt = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) begin mr_i = 1'b0; ck_rise_i = 1'b1; end
    repeat (6) @(posedge clk);
    #1 check_out("R8");
    step(1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, "R8");

    // Random level pairs mixed with occasional clears
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 25) == 0) clear_pulse();
      else step(1'($urandom), 1'($urandom), "R2");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule